// File: doc/BRIEF.md
# Low-Power Clock Mode Controller

This block decides, cycle by cycle, whether the processor core, the peripheral set and the oscillator receive a clock. It offers two sleep depths. In the shallow one (halt) only the core clock is gated: the timers and the interrupt inputs keep running, and an enabled interrupt request brings the core back. The core then resumes at the instruction after the sleep instruction, so no restart address is issued. In the deep one (stop) the core clock, the peripheral clock and the oscillator are all switched off. Only a reset ends it, and the core then restarts at a fixed restart address.

The decoder pulses a one-cycle halt or stop strobe. The block enters the requested mode only once the pipeline-empty flag is high. A strobe that arrives while the pipeline still holds work is kept pending until the flag rises. All enables and the mode status come from flops updated on the clock edge, so a downstream clock gate sees no mid-cycle change.

Top module: `lpclk_ctrl`

## Requirements
- R1: Each reset is synchronous and active high. During reset and in the cycle after it, mode reads 00 (running) and core_clk_en, periph_clk_en and osc_en read 1. On the first edge after reset is released, vec_load pulses high for exactly one cycle with vec_addr equal to RESTART_ADDR (default 16'h000C). Whenever vec_load is low, vec_addr reads 0.
- R2: A halt strobe while running with pipe_empty high gives, from the next edge: core_clk_en=0, periph_clk_en=1, osc_en=1, mode=01.
- R3: A stop strobe while running with pipe_empty high gives, from the next edge: core_clk_en=0, periph_clk_en=0, osc_en=0, mode=10.
- R4: A halt or stop strobe seen while pipe_empty is low is held pending. All enables stay 1 and mode stays 00 until the edge at which pipe_empty is high, and the held mode is entered at that edge.
- R5: In halt, an interrupt request whose bit in irq_en is 1 returns the block to running at the next edge (core_clk_en=1, mode=00) without a vec_load pulse.
- R6: In halt, interrupt requests whose irq_en bit is 0 have no effect.
- R7: In stop, no interrupt request, whether enabled or masked, has any effect. Only reset leaves stop, and the R1 restart pulse follows.
- R8: If the halt and stop strobes are high together, or a stop strobe comes while a halt is pending, stop is the mode taken.
- R9: Halt and stop strobes received while already in halt or stop are ignored.
- R10: Whenever osc_en is 0, core_clk_en and periph_clk_en are also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | One-cycle strobe: halt instruction decoded |
| stop_req | input | 1 | One-cycle strobe: stop instruction decoded |
| pipe_empty | input | 1 | High when the instruction pipeline holds no work |
| irq_req | input | NUM_IRQ | Interrupt request lines, external and internal |
| irq_en | input | NUM_IRQ | Per-line interrupt enable (1 = enabled) |
| core_clk_en | output | 1 | Core clock gate enable |
| periph_clk_en | output | 1 | Timer and interrupt logic clock enable |
| osc_en | output | 1 | Oscillator enable |
| vec_load | output | 1 | One-cycle strobe: load restart address |
| vec_addr | output | ADDR_W | Restart address, valid with vec_load |
| mode | output | 2 | 00 running, 01 halt, 10 stop |

## Verification
The bench builds the block with NUM_IRQ=6, so every wake line and mask bit can be toggled on its own. ADDR_W and RESTART_ADDR keep their defaults, which places the restart value 000C on a full 16-bit bus. With six lines, the random phase often produces patterns where requests are pending but all masked, next to patterns where exactly one enabled line fires. It also draws strobes while the pipeline is busy, strobes that collide, and resets during stop, and all of these meet the pending and priority paths many times.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_HALT_WAIT = 3'd1,
    ST_STOP_WAIT = 3'd2,
    ST_HALT      = 3'd3,
    ST_STOP      = 3'd4
  } lpc_state_e;

  localparam logic [1:0] MODE_RUN  = 2'b00;
  localparam logic [1:0] MODE_HALT = 2'b01;
  localparam logic [1:0] MODE_STOP = 2'b10;
endpackage

// File: rtl/lpc_wake.sv
module lpc_wake #(
  parameter int NUM_IRQ = 4
) (
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  output logic               wake
);
  logic [NUM_IRQ-1:0] live;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign live[i] = irq_req[i] & irq_en[i];
  end

  assign wake = |live;
endmodule

// File: rtl/lpc_fsm.sv
module lpc_fsm
  import lpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       halt_req,
  input  logic       stop_req,
  input  logic       pipe_empty,
  input  logic       wake,
  output lpc_state_e state_d
);
  lpc_state_e state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (stop_req)      state_d = pipe_empty ? ST_STOP : ST_STOP_WAIT;
        else if (halt_req) state_d = pipe_empty ? ST_HALT : ST_HALT_WAIT;
      end
      ST_HALT_WAIT: begin
        if (stop_req)      state_d = pipe_empty ? ST_STOP : ST_STOP_WAIT;
        else if (pipe_empty) state_d = ST_HALT;
      end
      ST_STOP_WAIT: if (pipe_empty) state_d = ST_STOP;
      ST_HALT:      if (wake) state_d = ST_RUN;
      ST_STOP:      state_d = ST_STOP;
      default:      state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end

  // R2: flushed halt strobe lands in halt
  a_r2_halt_entry: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && halt_req && !stop_req && pipe_empty) |=> state_q == ST_HALT);

  // R4: busy pipeline keeps the request pending
  a_r4_pending: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && (halt_req || stop_req) && !pipe_empty)
      |=> (state_q == ST_HALT_WAIT || state_q == ST_STOP_WAIT));

  // R6: no enabled request keeps halt
  a_r6_masked_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HALT && !wake) |=> state_q == ST_HALT);

  // R7: only reset ends stop
  a_r7_stop_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STOP) |=> state_q == ST_STOP);

  // R8: stop beats halt on collision
  a_r8_stop_wins: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && halt_req && stop_req && pipe_empty) |=> state_q == ST_STOP);
endmodule

// File: rtl/lpc_outregs.sv
module lpc_outregs
  import lpc_pkg::*;
#(
  parameter int                ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] RESTART_ADDR = 16'h000C
) (
  input  logic              clk,
  input  logic              rst,
  input  lpc_state_e        state_d,
  output logic              core_clk_en,
  output logic              periph_clk_en,
  output logic              osc_en,
  output logic              vec_load,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [1:0]        mode
);
  logic boot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      core_clk_en   <= 1'b1;
      periph_clk_en <= 1'b1;
      osc_en        <= 1'b1;
      mode          <= MODE_RUN;
      boot_q        <= 1'b1;
      vec_load      <= 1'b0;
      vec_addr      <= '0;
    end else begin
      core_clk_en   <= (state_d == ST_RUN) || (state_d == ST_HALT_WAIT) ||
                       (state_d == ST_STOP_WAIT);
      periph_clk_en <= (state_d != ST_STOP);
      osc_en        <= (state_d != ST_STOP);
      mode          <= (state_d == ST_HALT) ? MODE_HALT :
                       (state_d == ST_STOP) ? MODE_STOP : MODE_RUN;
      boot_q        <= 1'b0;
      vec_load      <= boot_q;
      vec_addr      <= boot_q ? RESTART_ADDR : '0;
    end
  end

  // R10: oscillator off implies every clock off
  a_r10_osc_off: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> (!core_clk_en && !periph_clk_en));

  // R1: restart strobe lasts one cycle and carries the address
  a_r1_vec_pulse: assert property (@(posedge clk) disable iff (rst)
    vec_load |=> !vec_load);
  a_r1_vec_addr: assert property (@(posedge clk) disable iff (rst)
    vec_load |-> vec_addr == RESTART_ADDR);

  // R5: core clock only stopped while a sleep mode is shown
  a_r5_core_mode: assert property (@(posedge clk) disable iff (rst)
    !core_clk_en |-> mode != MODE_RUN);
endmodule

// File: rtl/lpclk_ctrl.sv
module lpclk_ctrl
  import lpc_pkg::*;
#(
  parameter int                NUM_IRQ      = 6,
  parameter int                ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] RESTART_ADDR = 16'h000C
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               halt_req,
  input  logic               stop_req,
  input  logic               pipe_empty,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  output logic               core_clk_en,
  output logic               periph_clk_en,
  output logic               osc_en,
  output logic               vec_load,
  output logic [ADDR_W-1:0]  vec_addr,
  output logic [1:0]         mode
);
  logic       wake;
  lpc_state_e state_d;

  lpc_wake #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .irq_req (irq_req),
    .irq_en  (irq_en),
    .wake    (wake)
  );

  lpc_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .halt_req   (halt_req),
    .stop_req   (stop_req),
    .pipe_empty (pipe_empty),
    .wake       (wake),
    .state_d    (state_d)
  );

  lpc_outregs #(.ADDR_W(ADDR_W), .RESTART_ADDR(RESTART_ADDR)) u_out (
    .clk           (clk),
    .rst           (rst),
    .state_d       (state_d),
    .core_clk_en   (core_clk_en),
    .periph_clk_en (periph_clk_en),
    .osc_en        (osc_en),
    .vec_load      (vec_load),
    .vec_addr      (vec_addr),
    .mode          (mode)
  );
endmodule

// File: tb/tb_lpclk_ctrl.sv
module tb_lpclk_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 6;
  localparam logic [15:0] RADDR = 16'h000C;

  logic clk = 0, rst = 1, halt_req = 0, stop_req = 0, pipe_empty = 1;
  logic [NIRQ-1:0] irq_req = '0, irq_en = '0;
  logic core_clk_en, periph_clk_en, osc_en, vec_load;
  logic [15:0] vec_addr;
  logic [1:0] mode;

  int errors = 0, checks = 0;
  bit done = 0;
  int m_st = 0;  // 0 run,1 halt pend,2 stop pend,3 halt,4 stop
  bit m_boot = 1, m_vl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpclk_ctrl #(.NUM_IRQ(NIRQ)) dut (
    .clk(clk), .rst(rst), .halt_req(halt_req), .stop_req(stop_req),
    .pipe_empty(pipe_empty), .irq_req(irq_req), .irq_en(irq_en),
    .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
    .vec_load(vec_load), .vec_addr(vec_addr), .mode(mode));

  function automatic int next_st(int s, bit h, bit sp, bit pe, bit wk);
    case (s)
      0: return sp ? (pe ? 4 : 2) : h ? (pe ? 3 : 1) : 0;
      1: return sp ? (pe ? 4 : 2) : (pe ? 3 : 1);
      2: return pe ? 4 : 2;
      3: return wk ? 0 : 3;
      default: return 4;
    endcase
  endfunction

  function automatic logic [1:0] exp_mode(int s);
    return (s == 3) ? 2'b01 : (s == 4) ? 2'b10 : 2'b00;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit r, bit h, bit sp, bit pe, logic [NIRQ-1:0] iq,
                     logic [NIRQ-1:0] en, string tag);
    logic [15:0] ea;
    rst = r; halt_req = h; stop_req = sp; pipe_empty = pe; irq_req = iq; irq_en = en;
    @(posedge clk);
    if (r) begin m_st = 0; m_boot = 1; m_vl = 0; end
    else begin
      m_vl = m_boot; m_boot = 0;
      m_st = next_st(m_st, h, sp, pe, |(iq & en));
    end
    @(negedge clk);
    ea = m_vl ? RADDR : 16'h0;
    chk(mode == exp_mode(m_st), tag, "mode", {14'b0, mode}, {14'b0, exp_mode(m_st)});
    chk(core_clk_en == (m_st <= 2), tag, "core_clk_en", {15'b0, core_clk_en}, {15'b0, m_st <= 2});
    chk(periph_clk_en == (m_st != 4), tag, "periph_clk_en", {15'b0, periph_clk_en}, {15'b0, m_st != 4});
    chk(osc_en == (m_st != 4), tag, "osc_en", {15'b0, osc_en}, {15'b0, m_st != 4});
    chk(vec_load == m_vl, tag, "vec_load", {15'b0, vec_load}, {15'b0, m_vl});
    chk(vec_addr == ea, tag, "vec_addr", vec_addr, ea);
  endtask

  function automatic string st_tag(int s);
    case (s)
      0: return "R1";
      1, 2: return "R4";
      3: return "R2";
      default: return "R3";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    // R1: reset state and restart strobe
    cyc(1, 0, 0, 1, '0, '0, "R1");
    cyc(1, 0, 0, 1, '0, '0, "R1");
    cyc(0, 0, 0, 1, '0, '0, "R1");
    cyc(0, 0, 0, 1, '0, '0, "R1");
    // R2 halt entry, R6 masked requests, R5 enabled wake
    cyc(0, 1, 0, 1, '0, '0, "R2");
    cyc(0, 0, 0, 1, '0, '0, "R2");
    cyc(0, 0, 0, 1, 6'h3F, 6'h00, "R6");
    cyc(0, 0, 0, 1, 6'h15, 6'h2A, "R6");
    cyc(0, 1, 1, 1, 6'h00, 6'h3F, "R9");
    cyc(0, 0, 0, 1, 6'h20, 6'h20, "R5");
    cyc(0, 0, 0, 1, '0, '0, "R5");
    // R4 pending halt
    cyc(0, 1, 0, 0, '0, '0, "R4");
    cyc(0, 0, 0, 0, '0, '0, "R4");
    cyc(0, 0, 0, 0, '0, '0, "R4");
    cyc(0, 0, 0, 1, '0, '0, "R4");
    cyc(0, 0, 0, 1, 6'h01, 6'h01, "R5");
    // R8 stop upgrades pending halt
    cyc(0, 1, 0, 0, '0, '0, "R8");
    cyc(0, 0, 1, 0, '0, '0, "R8");
    cyc(0, 0, 0, 1, '0, '0, "R8");
    cyc(0, 0, 0, 1, 6'h3F, 6'h3F, "R7");
    cyc(0, 1, 0, 1, '0, '0, "R9");
    cyc(0, 0, 0, 1, '0, '0, "R10");
    cyc(1, 0, 0, 1, '0, '0, "R7");
    cyc(0, 0, 0, 1, '0, '0, "R7");
    cyc(0, 0, 0, 1, '0, '0, "R7");
    // R3 direct stop, R8 collision
    cyc(0, 0, 1, 1, '0, '0, "R3");
    cyc(1, 0, 0, 1, '0, '0, "R3");
    cyc(0, 0, 0, 1, '0, '0, "R3");
    cyc(0, 1, 1, 1, '0, '0, "R8");
    cyc(1, 0, 0, 1, '0, '0, "R8");
    cyc(0, 0, 0, 1, '0, '0, "R1");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit r, h, sp, pe;
      logic [NIRQ-1:0] iq, en;
      r  = ($urandom_range(0, 79) == 0);
      h  = ($urandom_range(0, 7) == 0);
      sp = ($urandom_range(0, 15) == 0);
      pe = $urandom_range(0, 1) == 1;
      iq = ($urandom_range(0, 3) == 0) ? NIRQ'($urandom) : '0;
      en = NIRQ'($urandom);
      cyc(r, h, sp, pe, iq, en, st_tag(next_st(m_st, h, sp, pe, |(iq & en))));
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule